// File: doc/BRIEF.md
# Collision retry FIFO rewind controller

This controller runs the retry side of a half-duplex transmitter. As a frame drains from the local transmit FIFO, the controller counts the bytes that have gone out on the wire. It also holds the FIFO read pointer of the frame's first byte. When a collision is reported, the controller acts on that count. A collision that arrives early enough lets the frame be replayed straight from the FIFO: the controller pulses a restore request carrying the saved pointer and raises a retry request. It then waits until the backoff logic answers with a go strobe.

A collision that arrives too late cannot be repaired locally, so the frame is dropped and a late-collision flag is raised. The frame is also dropped when its retry budget is spent, and then an excessive-collision flag is raised. In both cases the abort pulse serves as the interrupt request. A frame that ends normally produces a release pulse so that its FIFO space can be freed. All event inputs are single-cycle strobes and all outputs are registered. The block moves no data words, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `ccr_rewind_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, every pulse output is 0, retry_req_o is 0, both flags are 0, coll_cnt_o is 0 and restore_ptr_o is 0.
- R2: frame_start_i is accepted only while no frame is active (not sending, not waiting for retry). Accepting it clears the byte tally, the collision count and both flags.
- R3: The saved pointer, shown on restore_ptr_o, takes rd_ptr_i on the first byte_sent_i of each accepted frame. Byte strobes in later retries of the same frame do not recapture it.
- R4: A collision while sending, with at most 64 bytes sent (exactly 64 included) and fewer than 14 earlier collisions in the frame, has three effects one cycle later: a single-cycle ptr_restore_o pulse, coll_cnt_o incremented by one, and retry_req_o asserted.
- R5: retry_req_o stays high until retry_go_i is seen. retry_go_i then resumes sending with the byte tally cleared. retry_go_i has no effect at any other time.
- R6: A collision while sending, with 65 or more bytes sent, gives a single-cycle abort_o pulse and sets late_coll_o one cycle later. It gives no restore, leaves coll_cnt_o unchanged and goes idle with no retry. Only a new frame_start_i resumes transmission.
- R7: An in-window collision that would be the 15th of the frame gives an abort_o pulse, sets coll_cnt_o to 4'b1111 and sets excess_coll_o. No retry follows.
- R8: frame_done_i while sending, with no collision in the same cycle, gives a single-cycle release_o pulse one cycle later and goes idle. coll_cnt_o keeps its value.
- R9: While sending, a collision takes priority over frame_done_i and byte_sent_i in the same cycle, and frame_done_i takes priority over byte_sent_i. byte_sent_i, collision_i and frame_done_i have no effect outside the sending state.
- R10: late_coll_o and excess_coll_o stay set until the next accepted frame_start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | New transmit command strobe |
| byte_sent_i | input | 1 | One byte left the FIFO onto the wire |
| collision_i | input | 1 | Collision detected strobe |
| frame_done_i | input | 1 | Frame finished without collision |
| retry_go_i | input | 1 | Backoff wait is over |
| rd_ptr_i | input | PTR_W | Current FIFO read pointer |
| ptr_restore_o | output | 1 | Rewind FIFO read pointer to restore_ptr_o |
| restore_ptr_o | output | PTR_W | Saved frame-start pointer |
| retry_req_o | output | 1 | Waiting for backoff before retry |
| abort_o | output | 1 | Frame aborted, interrupt request |
| release_o | output | 1 | Frame done, free its FIFO space |
| late_coll_o | output | 1 | Out-of-window collision flag |
| excess_coll_o | output | 1 | Retry budget exhausted flag |
| coll_cnt_o | output | 4 | Collisions of the current frame |

## Verification
The properties assume that each event input is a one-cycle strobe and that retry_go_i is only meaningful while a retry is pending. They do not assume that the inputs respect the state, because the design is required to ignore strobes that arrive in the wrong state. The stimulus deliberately sends byte, collision, done and go strobes in the idle and waiting states, and sends a collision together with a byte or done strobe. It places collisions at exactly 64 and 65 sent bytes, so that the properties and the reference model see both sides of the window edge.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } ccr_state_e;

  // decoded events after state qualification and priority
  typedef struct packed {
    logic start;
    logic coll;
    logic done;
    logic byte_ok;
    logic go;
  } ccr_evt_s;

endpackage

// File: rtl/ccr_win_cnt.sv
// Saturating tally of bytes sent in the current attempt.
module ccr_win_cnt #(
  parameter int WINDOW = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic past_win_o
);
  localparam int BC_W = $clog2(WINDOW + 2);
  localparam logic [BC_W-1:0] LIMIT = BC_W'(WINDOW + 1);

  logic [BC_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && (cnt_q != LIMIT)) begin
      cnt_q <= cnt_q + BC_W'(1);
    end
  end

  // exactly WINDOW bytes is still inside the window
  assign past_win_o = (cnt_q == LIMIT);

endmodule

// File: rtl/ccr_ptr_hold.sv
// Holds the FIFO read pointer of the frame's first byte.
module ccr_ptr_hold #(
  parameter int PTR_W           = 10,
  parameter bit CAPTURE_ON_BYTE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             byte_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic [PTR_W-1:0] saved_o
);
  logic [PTR_W-1:0] saved_q;

  generate
    if (CAPTURE_ON_BYTE) begin : g_on_byte
      logic pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q  <= 1'b0;
          saved_q <= '0;
        end else if (arm_i) begin
          pend_q <= 1'b1;
        end else if (byte_i && pend_q) begin
          pend_q  <= 1'b0;
          saved_q <= ptr_i;
        end
      end
    end else begin : g_on_start
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          saved_q <= '0;
        end else if (arm_i) begin
          saved_q <= ptr_i;
        end
      end
      logic unused_byte;
      assign unused_byte = byte_i;
    end
  endgenerate

  assign saved_o = saved_q;

endmodule

// File: rtl/ccr_coll_cnt.sv
// Per-frame collision counter; flags the value one below full scale.
module ccr_coll_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] FULL = '1;
  localparam logic [CNT_W-1:0] PRE  = FULL - CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && (cnt_q != FULL)) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == PRE);

endmodule

// File: rtl/ccr_rewind_ctrl.sv
module ccr_rewind_ctrl #(
  parameter int PTR_W  = 10,
  parameter int WINDOW = 64,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start_i,
  input  logic             byte_sent_i,
  input  logic             collision_i,
  input  logic             frame_done_i,
  input  logic             retry_go_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  output logic             ptr_restore_o,
  output logic [PTR_W-1:0] restore_ptr_o,
  output logic             retry_req_o,
  output logic             abort_o,
  output logic             release_o,
  output logic             late_coll_o,
  output logic             excess_coll_o,
  output logic [CNT_W-1:0] coll_cnt_o
);
  import ccr_pkg::*;

  ccr_state_e state_q, state_d;
  ccr_evt_s   ev;
  logic past_win, cnt_last;
  logic do_rewind, do_late, do_excess;
  logic restore_q, abort_q, release_q, late_q, excess_q;

  // event decode with priority: collision > done > byte
  always_comb begin
    ev.start   = (state_q == ST_IDLE) && frame_start_i;
    ev.coll    = (state_q == ST_SEND) && collision_i;
    ev.done    = (state_q == ST_SEND) && !collision_i && frame_done_i;
    ev.byte_ok = (state_q == ST_SEND) && !collision_i && !frame_done_i && byte_sent_i;
    ev.go      = (state_q == ST_WAIT) && retry_go_i;
  end

  assign do_late   = ev.coll && past_win;
  assign do_excess = ev.coll && !past_win && cnt_last;
  assign do_rewind = ev.coll && !past_win && !cnt_last;

  ccr_win_cnt #(.WINDOW(WINDOW)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (ev.start || ev.go),
    .inc_i      (ev.byte_ok),
    .past_win_o (past_win)
  );

  ccr_ptr_hold #(.PTR_W(PTR_W), .CAPTURE_ON_BYTE(1'b1)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (ev.start),
    .byte_i  (ev.byte_ok),
    .ptr_i   (rd_ptr_i),
    .saved_o (restore_ptr_o)
  );

  ccr_coll_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (ev.start),
    .inc_i  (do_rewind || do_excess),
    .cnt_o  (coll_cnt_o),
    .last_o (cnt_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (ev.start) state_d = ST_SEND;
      ST_SEND: begin
        if (do_rewind)                   state_d = ST_WAIT;
        else if (do_late || do_excess)   state_d = ST_IDLE;
        else if (ev.done)                state_d = ST_IDLE;
      end
      ST_WAIT: if (ev.go) state_d = ST_SEND;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      restore_q <= 1'b0;
      abort_q   <= 1'b0;
      release_q <= 1'b0;
      late_q    <= 1'b0;
      excess_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      restore_q <= do_rewind;
      abort_q   <= do_late || do_excess;
      release_q <= ev.done;
      if (ev.start) begin
        late_q   <= 1'b0;
        excess_q <= 1'b0;
      end else begin
        if (do_late)   late_q   <= 1'b1;
        if (do_excess) excess_q <= 1'b1;
      end
    end
  end

  assign ptr_restore_o = restore_q;
  assign abort_o       = abort_q;
  assign release_o     = release_q;
  assign late_coll_o   = late_q;
  assign excess_coll_o = excess_q;
  assign retry_req_o   = (state_q == ST_WAIT);

endmodule

// File: rtl/ccr_rewind_chk.sv
module ccr_rewind_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             retry_go_i,
  input logic             ptr_restore_o,
  input logic             retry_req_o,
  input logic             abort_o,
  input logic             release_o,
  input logic             late_coll_o,
  input logic             excess_coll_o,
  input logic [CNT_W-1:0] coll_cnt_o
);
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ptr_restore_o, abort_o, release_o}));

  assert_restore_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_restore_o |-> retry_req_o);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_restore_o |-> (coll_cnt_o == CNT_W'($past(coll_cnt_o) + 1)));

  assert_wait_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_req_o && !retry_go_i) |=> retry_req_o);

  assert_late_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_coll_o) |-> (abort_o && !retry_req_o));

  assert_excess_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(excess_coll_o) |-> (abort_o && (coll_cnt_o == '1)));

  assert_flags_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(late_coll_o && excess_coll_o));

  assert_abort_no_retry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !retry_req_o);
endmodule

bind ccr_rewind_ctrl ccr_rewind_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .retry_go_i    (retry_go_i),
  .ptr_restore_o (ptr_restore_o),
  .retry_req_o   (retry_req_o),
  .abort_o       (abort_o),
  .release_o     (release_o),
  .late_coll_o   (late_coll_o),
  .excess_coll_o (excess_coll_o),
  .coll_cnt_o    (coll_cnt_o)
);

// File: tb/ccr_rewind_ctrl_tb.sv
`timescale 1ns/1ps
module ccr_rewind_ctrl_tb;
  localparam int PTR_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 0, byte_sent = 0, collision = 0, frame_done = 0, retry_go = 0;
  logic [PTR_W-1:0] rd_ptr = '0;
  logic ptr_restore, retry_req, abort_p, release_p, late_f, excess_f;
  logic [PTR_W-1:0] restore_ptr;
  logic [3:0] coll_cnt;

  always #2.5 clk = ~clk;

  ccr_rewind_ctrl #(.PTR_W(PTR_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .frame_start_i(frame_start), .byte_sent_i(byte_sent), .collision_i(collision),
    .frame_done_i(frame_done), .retry_go_i(retry_go), .rd_ptr_i(rd_ptr),
    .ptr_restore_o(ptr_restore), .restore_ptr_o(restore_ptr), .retry_req_o(retry_req),
    .abort_o(abort_p), .release_o(release_p), .late_coll_o(late_f),
    .excess_coll_o(excess_f), .coll_cnt_o(coll_cnt)
  );

  int errors = 0, checks = 0, pctr = 100;
  string cur_req = "R1";
  bit finished = 0;

  // reference model: 0 idle, 1 sending, 2 waiting
  int m_state = 0, m_bytes = 0, m_cnt = 0, m_saved = 0;
  bit m_first = 0, m_owc = 0, m_exc = 0, m_rst = 0, m_abt = 0, m_rel = 0;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("ptr_restore", int'(ptr_restore), int'(m_rst));
    chk("restore_ptr", int'(restore_ptr), m_saved);
    chk("retry_req", int'(retry_req), int'(m_state == 2));
    chk("abort", int'(abort_p), int'(m_abt));
    chk("release", int'(release_p), int'(m_rel));
    chk("late_coll", int'(late_f), int'(m_owc));
    chk("excess_coll", int'(excess_f), int'(m_exc));
    chk("coll_cnt", int'(coll_cnt), m_cnt);
  endtask

  task automatic model(bit fs, bit bs, bit col, bit dn, bit go, int ptr);
    m_rst = 0; m_abt = 0; m_rel = 0;
    case (m_state)
      0: if (fs) begin
        m_state = 1; m_bytes = 0; m_cnt = 0; m_owc = 0; m_exc = 0; m_first = 1;
      end
      1: if (col) begin
        if (m_bytes > 64) begin m_abt = 1; m_owc = 1; m_state = 0; end
        else if (m_cnt == 14) begin m_cnt = 15; m_abt = 1; m_exc = 1; m_state = 0; end
        else begin m_cnt++; m_rst = 1; m_state = 2; end
      end else if (dn) begin
        m_rel = 1; m_state = 0;
      end else if (bs) begin
        if (m_first) begin m_saved = ptr; m_first = 0; end
        if (m_bytes < 65) m_bytes++;
      end
      2: if (go) begin m_state = 1; m_bytes = 0; end
      default: m_state = 0;
    endcase
  endtask

  task automatic step(bit fs, bit bs, bit col, bit dn, bit go);
    frame_start = fs; byte_sent = bs; collision = col; frame_done = dn; retry_go = go;
    rd_ptr = PTR_W'(pctr);
    model(fs, bs, col, dn, go, pctr % (1 << PTR_W));
    @(posedge clk);
    @(negedge clk);
    compare();
    if (bs) pctr++;
  endtask

  task automatic bytes(int n);
    for (int i = 0; i < n; i++) step(0, 1, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare();
    rst_n = 1'b1;
    @(negedge clk);
    compare();
    // R9: strobes while idle are ignored
    cur_req = "R9";
    step(0, 1, 1, 1, 1);
    step(0, 1, 0, 0, 0);
    // R3 R8: normal frame
    cur_req = "R3";
    step(1, 0, 0, 0, 0);
    bytes(10);
    cur_req = "R8";
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0);
    // R4: collision at exactly 64 bytes is in-window
    cur_req = "R4";
    step(1, 0, 0, 0, 0);
    bytes(64);
    step(0, 0, 1, 0, 0);
    // R5 R2: wait, ignore start/byte/collision, then go
    cur_req = "R5";
    step(1, 1, 1, 1, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    // R3: retry bytes must not recapture; R6: late collision at 65 bytes
    cur_req = "R6";
    bytes(65);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1);
    step(0, 1, 1, 0, 0);
    // R10 R2: flags cleared by new frame
    cur_req = "R10";
    step(0, 0, 0, 0, 0);
    cur_req = "R2";
    step(1, 0, 0, 0, 0);
    // R9: collision wins over byte and done
    cur_req = "R9";
    bytes(5);
    step(0, 1, 1, 1, 0);
    step(0, 0, 0, 0, 1);
    step(0, 1, 0, 1, 0);
    // R7: 15 in-window collisions
    cur_req = "R7";
    step(1, 0, 0, 0, 0);
    for (int k = 0; k < 15; k++) begin
      bytes(3);
      step(0, 0, 1, 0, 0);
      step(0, 0, 0, 0, 0);
      if (k < 14) step(0, 0, 0, 0, 1);
    end
    cur_req = "R10";
    step(0, 1, 1, 0, 1);
    step(0, 0, 0, 0, 0);
    cur_req = "R2";
    step(1, 0, 0, 0, 0);
    bytes(2);
    cur_req = "R8";
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=1 exp=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule